// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block controls the start-up and power-down of a clock generator with many outputs. One external pin has two jobs. Before power-good is seen it is high, and nothing starts. When it first goes low, that counts as power-good and starts a fixed sequence:

1. Wait a settling interval.
2. Capture the configuration straps.
3. Wait a hold interval.
4. Wait for the PLL to report lock.
5. Release the clock outputs.

After that first low level, the same pin is read every cycle as a power-down request, with high meaning power down. Later edges on the pin never restart the sequence.

Each output has two configuration bits. The enable bit selects driven or tri-stated while running. The power-down mode bit selects driven-low or high impedance while powered down. Both intervals are counted in ticks of a reference clock, given as a one-cycle pulse. The tick limits are parameters.

Top module: `clkseq_top`

## Requirements
- R1: After reset, `strap_valid` is 0, `pd_active` is 0, every `clk_run` bit is 0 and every `clk_hiz` bit is 1.
- R2: While `pgpd_pin` stays high after reset, the block stays idle, whatever the reference ticks do. Straps are not captured and no output runs.
- R3: The straps are captured once. This happens `T_SETTLE` reference ticks after `pgpd_pin` first goes low. Capture sets `strap_valid` and places the straps on `strap_q` (bits [4:2] frequency select, bit 1 test select, bit 0 debug-port enable). `strap_q` then holds even when the strap pins change.
- R4: After capture, no output runs until two conditions are both met: a further `T_HOLD` ticks have passed, and `pll_locked` is high.
- R5: While running, `clk_run[i]` equals `out_en_cfg[i]` and `clk_hiz[i]` equals the inverse of `out_en_cfg[i]`.
- R6: A high level on `pgpd_pin` while running puts the block into power-down. Then `pd_active` is 1 and every `clk_run` bit is 0. `clk_hiz[i]` is 1 when `out_en_cfg[i]` is 0 or `pd_hiz_cfg[i]` is 1, and 0 otherwise.
- R7: Power-down ends on the first reference tick that finds `pgpd_pin` low. The outputs return to the state set by `out_en_cfg`, without capturing the straps again.
- R8: Once `pgpd_pin` has first gone low, later toggles on it do not restart the sequence. `strap_valid` stays 1 and `strap_q` keeps its captured value.
- R9: If `pgpd_pin` is high when the sequence completes, the block goes straight into power-down and no output ever runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| pgpd_pin | input | 1 | Shared pin: power-good when low (first time), then power-down request when high |
| pll_locked | input | 1 | PLL lock indication |
| strap_pins | input | 5 | Raw strap levels: [4:2] frequency select, [1] test select, [0] debug enable |
| out_en_cfg | input | N_OUT | Per-output enable |
| pd_hiz_cfg | input | N_OUT | Per-output power-down mode: 0 driven, 1 high impedance |
| strap_q | output | 5 | Captured straps |
| strap_valid | output | 1 | Straps have been captured |
| clk_run | output | N_OUT | Output may toggle |
| clk_hiz | output | N_OUT | Output is tri-stated |
| pd_active | output | 1 | Block is in power-down |

## Verification
The hardest case to reach from the ports is the one where the power-down level is already present when the sequence finishes. In that case the block must go from the lock wait straight into power-down without a single running cycle. The stimulus makes the pin low to start the sequence, raises it again within a couple of ticks, and holds it high with the PLL locked through both intervals. It then watches `clk_run` on every cycle of that window.

A second case is a single-cycle high glitch on the pin after start-up. The check there is that this only drops the outputs briefly. The straps must not be captured again and the intervals must not run again.

// File: rtl/clkseq_pkg.sv
// Package: shared types for the power-up sequencer.
// Assumes: nothing beyond the standard language.
package clkseq_pkg;

    // Sequencer states, in start-up order.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_LOCK   = 3'd4,
        ST_RUN    = 3'd5,
        ST_PDWN   = 3'd6
    } seq_state_t;

    // Output mode that the FSM broadcasts to every output slice.
    typedef enum logic [1:0] {
        OM_OFF = 2'd0,
        OM_RUN = 2'd1,
        OM_PD  = 2'd2
    } out_mode_t;

    // Captured strap fields; the bit order is the order used on the strap bus.
    typedef struct packed {
        logic [2:0] fsel;
        logic       test_sel;
        logic       dbg_en;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

endpackage

// File: rtl/clkseq_sync.sv
// Module: two-flop synchronizer for the shared power-good/power-down pin.
// Assumes: the pin rests high before power-good, so the flops reset to 1.
module clkseq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_s
);

    logic meta_q;

    // Carry the raw pin through two flops into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            pin_s  <= 1'b1;
        end else begin
            meta_q <= pin_raw;
            pin_s  <= meta_q;
        end
    end

endmodule

// File: rtl/clkseq_timer.sv
// Module: saturating counter of reference ticks with a run-time limit.
// Assumes: clr has priority; limit stays stable while a wait is in progress.
module clkseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q >= limit);

    // Count ticks from the last clear until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/clkseq_fsm.sv
// Module: start-up and power-down state machine; also holds the strap capture.
// Assumes: pin_s is synchronized; pll_locked and strap_raw are quasi-static.
module clkseq_fsm
    import clkseq_pkg::*;
#(
    parameter int T_SETTLE = 3580,
    parameter int T_HOLD   = 25773,
    localparam int TMAX    = (T_SETTLE > T_HOLD) ? T_SETTLE : T_HOLD,
    localparam int TW      = $clog2(TMAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               pin_s,
    input  logic               pll_locked,
    input  logic [STRAP_W-1:0] strap_raw,
    output out_mode_t          mode,
    output logic [STRAP_W-1:0] strap_q,
    output logic               strap_valid,
    output logic               pd_active
);

    seq_state_t   st_q, st_d;
    logic         tmr_clr;
    logic         tmr_exp;
    logic [TW-1:0] tmr_lim;
    strap_t       strap_r;

    // Restart the timer whenever the state changes.
    assign tmr_clr = (st_d != st_q);
    // Choose the limit for the wait now in progress.
    assign tmr_lim = (st_q == ST_HOLD) ? TW'(T_HOLD) : TW'(T_SETTLE);

    clkseq_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (ref_tick),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    // Next-state logic for the start-up sequence and power-down handling.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (!pin_s) st_d = ST_SETTLE;
            ST_SETTLE: if (tmr_exp) st_d = ST_SAMPLE;
            ST_SAMPLE: st_d = ST_HOLD;
            ST_HOLD:   if (tmr_exp) st_d = ST_LOCK;
            ST_LOCK:   if (pll_locked) st_d = pin_s ? ST_PDWN : ST_RUN;
            ST_RUN:    if (pin_s) st_d = ST_PDWN;
            ST_PDWN:   if (!pin_s && ref_tick) st_d = ST_RUN;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the straps once, in the sample state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_r     <= '0;
            strap_valid <= 1'b0;
        end else if (st_q == ST_SAMPLE && !strap_valid) begin
            strap_r     <= strap_t'(strap_raw);
            strap_valid <= 1'b1;
        end
    end

    assign strap_q   = strap_r;
    assign pd_active = (st_q == ST_PDWN);

    // Tell the output slices which mode to use.
    always_comb begin
        unique case (st_q)
            ST_RUN:  mode = OM_RUN;
            ST_PDWN: mode = OM_PD;
            default: mode = OM_OFF;
        endcase
    end

endmodule

// File: rtl/clkseq_outctl.sv
// Module: per-output run / tri-state control registers, one slice per output.
// Assumes: out_en and pd_hiz are quasi-static configuration bits.
module clkseq_outctl
    import clkseq_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  out_mode_t        mode,
    input  logic [N_OUT-1:0] out_en,
    input  logic [N_OUT-1:0] pd_hiz,
    output logic [N_OUT-1:0] run,
    output logic [N_OUT-1:0] hiz
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_slice
        // Register this output's run and tri-state controls for the current mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run[i] <= 1'b0;
                hiz[i] <= 1'b1;
            end else begin
                unique case (mode)
                    OM_RUN: begin
                        run[i] <= out_en[i];
                        hiz[i] <= ~out_en[i];
                    end
                    OM_PD: begin
                        run[i] <= 1'b0;
                        hiz[i] <= ~out_en[i] | pd_hiz[i];
                    end
                    default: begin
                        run[i] <= 1'b0;
                        hiz[i] <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/clkseq_top.sv
// Module: top level of the clock generator power-up sequencer.
// Assumes: ref_tick is a one-cycle pulse in the clk domain; the pin may be asynchronous.
module clkseq_top #(
    parameter int N_OUT    = 8,
    parameter int T_SETTLE = 3580,
    parameter int T_HOLD   = 25773
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             pgpd_pin,
    input  logic             pll_locked,
    input  logic [4:0]       strap_pins,
    input  logic [N_OUT-1:0] out_en_cfg,
    input  logic [N_OUT-1:0] pd_hiz_cfg,
    output logic [4:0]       strap_q,
    output logic             strap_valid,
    output logic [N_OUT-1:0] clk_run,
    output logic [N_OUT-1:0] clk_hiz,
    output logic             pd_active
);

    import clkseq_pkg::*;

    logic      pin_s;
    out_mode_t mode;

    clkseq_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pgpd_pin),
        .pin_s   (pin_s)
    );

    clkseq_fsm #(.T_SETTLE(T_SETTLE), .T_HOLD(T_HOLD)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick    (ref_tick),
        .pin_s       (pin_s),
        .pll_locked  (pll_locked),
        .strap_raw   (strap_pins),
        .mode        (mode),
        .strap_q     (strap_q),
        .strap_valid (strap_valid),
        .pd_active   (pd_active)
    );

    clkseq_outctl #(.N_OUT(N_OUT)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .out_en (out_en_cfg),
        .pd_hiz (pd_hiz_cfg),
        .run    (clk_run),
        .hiz    (clk_hiz)
    );

endmodule

// File: rtl/clkseq_chk.sv
// Module: property checker for clkseq_top, attached by bind.
// Assumes: the same synchronous active-low reset as the design.
module clkseq_chk #(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] out_en_cfg,
    input logic [4:0]       strap_q,
    input logic             strap_valid,
    input logic [N_OUT-1:0] clk_run,
    input logic [N_OUT-1:0] clk_hiz,
    input logic             pd_active
);

    // R3 / R8: once captured, the straps never change.
    p_strap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strap_valid |=> (strap_valid && $stable(strap_q)));

    // R4: no output runs before the straps have been captured.
    p_no_early_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run != '0) |-> strap_valid);

    // R5: a running output is always an enabled one, and never tri-stated.
    p_run_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_run & ~$past(out_en_cfg)) == '0) && ((clk_run & clk_hiz) == '0));

    // R6: in power-down, nothing runs from the next cycle on.
    p_pd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> (clk_run == '0));

endmodule

bind clkseq_top clkseq_chk #(.N_OUT(N_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_en_cfg  (out_en_cfg),
    .strap_q     (strap_q),
    .strap_valid (strap_valid),
    .clk_run     (clk_run),
    .clk_hiz     (clk_hiz),
    .pd_active   (pd_active)
);

// File: tb/clkseq_top_test.sv
module clkseq_top_test;

    localparam int N   = 6;
    localparam int TS  = 8;
    localparam int TH  = 12;
    localparam int DIV = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_tick = 1'b0;
    logic         pgpd_pin = 1'b1;
    logic         pll_locked = 1'b0;
    logic [4:0]   strap_pins = '0;
    logic [N-1:0] out_en_cfg = '0;
    logic [N-1:0] pd_hiz_cfg = '0;
    logic [4:0]   strap_q;
    logic         strap_valid;
    logic [N-1:0] clk_run;
    logic [N-1:0] clk_hiz;
    logic         pd_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    clkseq_top #(.N_OUT(N), .T_SETTLE(TS), .T_HOLD(TH)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pgpd_pin(pgpd_pin),
        .pll_locked(pll_locked), .strap_pins(strap_pins), .out_en_cfg(out_en_cfg),
        .pd_hiz_cfg(pd_hiz_cfg), .strap_q(strap_q), .strap_valid(strap_valid),
        .clk_run(clk_run), .clk_hiz(clk_hiz), .pd_active(pd_active)
    );

    always #2 clk = ~clk;

    // Reference tick: one cycle high every DIV cycles, driven on the falling edge.
    initial begin
        forever begin
            for (int k = 0; k < DIV; k++) begin
                @(negedge clk);
                ref_tick = (k == 0);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pgpd_pin = 1'b1; pll_locked = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 strap_valid", 32'(strap_valid), 32'd0);
        check("R1 pd_active", 32'(pd_active), 32'd0);
        check("R1 clk_run", 32'(clk_run), 32'd0);
        check("R1 clk_hiz", 32'(clk_hiz), 32'(6'h3F));
    endtask

    task automatic t_idle();
        pll_locked = 1'b1; out_en_cfg = 6'h3F;
        wait_cyc(40 * DIV);
        check("R2 strap_valid idle", 32'(strap_valid), 32'd0);
        check("R2 clk_run idle", 32'(clk_run), 32'd0);
        pll_locked = 1'b0;
    endtask

    // Full start-up with PLL late; ends in running state.
    task automatic t_startup();
        strap_pins = 5'b10110; out_en_cfg = 6'b101101; pd_hiz_cfg = 6'b000111;
        pgpd_pin = 1'b0;
        wait_cyc((TS - 2) * DIV);
        check("R3 not yet captured", 32'(strap_valid), 32'd0);
        wait_cyc(5 * DIV);
        check("R3 captured", 32'(strap_valid), 32'd1);
        check("R3 strap value", 32'(strap_q), 32'(5'b10110));
        strap_pins = 5'b01001;
        wait_cyc((TH + 4) * DIV);
        check("R4 no run before lock", 32'(clk_run), 32'd0);
        pll_locked = 1'b1;
        wait_cyc(5);
        check("R5 run = enable", 32'(clk_run), 32'(6'b101101));
        check("R5 hiz = ~enable", 32'(clk_hiz), 32'(6'b010010));
        check("R3 strap held", 32'(strap_q), 32'(5'b10110));
    endtask

    task automatic t_powerdown();
        pgpd_pin = 1'b1;
        wait_cyc(6);
        check("R6 pd_active", 32'(pd_active), 32'd1);
        check("R6 run off", 32'(clk_run), 32'd0);
        check("R6 hiz mode", 32'(clk_hiz), 32'(6'b010111));
        out_en_cfg = 6'b110011;
        wait_cyc(3);
        check("R6 hiz new cfg", 32'(clk_hiz), 32'(6'b001111));
        pgpd_pin = 1'b0;
        wait_cyc(3 + 2 * DIV);
        check("R7 pd released", 32'(pd_active), 32'd0);
        check("R7 run restored", 32'(clk_run), 32'(6'b110011));
        check("R7 strap kept", 32'(strap_q), 32'(5'b10110));
    endtask

    task automatic t_toggle();
        strap_pins = 5'b11111;
        pgpd_pin = 1'b1;
        wait_cyc(1);
        pgpd_pin = 1'b0;
        wait_cyc(4 + 2 * DIV);
        check("R8 valid stays", 32'(strap_valid), 32'd1);
        check("R8 no recapture", 32'(strap_q), 32'(5'b10110));
        check("R8 no restart", 32'(clk_run), 32'(6'b110011));
    endtask

    // Power-down level present when the sequence completes.
    task automatic t_pd_at_start();
        int ran;
        do_reset();
        strap_pins = 5'b00101; out_en_cfg = 6'h3F; pd_hiz_cfg = 6'b110000;
        pll_locked = 1'b1;
        pgpd_pin = 1'b0;
        wait_cyc(2 * DIV);
        pgpd_pin = 1'b1;
        ran = 0;
        for (int c = 0; c < (TS + TH + 6) * DIV; c++) begin
            @(negedge clk);
            if (clk_run != '0) ran++;
        end
        check("R9 never ran", 32'(ran), 32'd0);
        check("R9 pd_active", 32'(pd_active), 32'd1);
        check("R9 hiz mode", 32'(clk_hiz), 32'(6'b110000));
        check("R9 straps", 32'(strap_q), 32'(5'b00101));
    endtask

    initial begin
        t_reset_state();
        t_idle();
        t_startup();
        t_powerdown();
        t_toggle();
        t_pd_at_start();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule